// File: doc/BRIEF.md
# Control Endpoint IN Handshake Controller

This block holds the IN-direction control state of a USB control endpoint and chooses the handshake for every IN token. Software reads and writes one 8-bit control byte. The byte holds a force-NAK bit, a force-STALL bit, a one-shot short-packet request and strobes that set or clear the data toggle. The serial engine reports four events to the block: the start of an IN token, the end of an outgoing packet, a host ACK and the completion of a SETUP stage.

When a token starts, the block registers its answer: DATA, NAK or STALL. It holds that answer for the whole transaction. A write that arrives during the transaction therefore only shapes the next one. A SETUP completion raises an internal pending flag. While that flag is set, the endpoint is locked into NAK and STALL is kept off, and an interrupt-status clear input releases the flag. The data PID toggle is forced to 1 on SETUP and advances only when the host acknowledges a data packet.

There is no data stream at this block's edge. The answer is a plain status pair: `hs_valid` marks an open transaction and `hs_resp` gives the answer. The serial engine samples this pair and never applies back-pressure.

Top module: `ep_in_hs_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `hs_valid` is 0, `hs_resp` is 0 and `data_pid` is 0.
- R2: A token that starts while force-STALL (bit 6) is 1 is answered with STALL (`hs_resp`=3), whatever force-NAK holds.
- R3: A token that starts while force-NAK (bit 7) is 1 and force-STALL is 0 is answered with NAK (`hs_resp`=2).
- R4: When neither force bit is set, a token is answered with DATA (`hs_resp`=1) if short-packet (bit 5) is 1 or the FIFO level is at least MPS bytes. Otherwise it is answered with NAK. An answer is registered one cycle after `tok_start`.
- R5: `setup_done` sets the pending flag, force-NAK and toggle to 1 and force-STALL to 0. While the flag is 1, writes cannot change bits 7 and 6. This includes a write in the same cycle as `setup_clr`.
- R6: Once the flag has been cleared, writes to bits 7 and 6 take effect again.
- R7: The short-packet bit returns to 0 by itself when `pkt_sent` ends a DATA transaction.
- R8: Writing 1 to bit 0 sets the toggle and writing 1 to bit 1 clears it. If both are written as 1, the set wins. A `setup_done` in the same cycle overrides both.
- R9: The toggle inverts only on `host_ack` of a DATA transaction. A `host_ack` during a NAK transaction ends the transaction and leaves the toggle unchanged.
- R10: `hs_resp` holds its value for the whole transaction. A write during the transaction, or in the same cycle as `tok_start`, affects only later tokens.
- R11: Bits 4, 3, 1 and 0 read as 0. Bit 2 reads the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control byte readback |
| setup_done | input | 1 | SETUP stage complete, one-cycle pulse |
| setup_clr | input | 1 | Clears the SETUP pending flag |
| fifo_level | input | LVL_W | Bytes currently held in the IN FIFO |
| tok_start | input | 1 | IN token received, one-cycle pulse |
| pkt_sent | input | 1 | Outgoing packet finished, one-cycle pulse |
| host_ack | input | 1 | Host handshake ACK received, one-cycle pulse |
| hs_valid | output | 1 | A transaction is open |
| hs_resp | output | 2 | Answer: 0 none, 1 DATA, 2 NAK, 3 STALL |
| data_pid | output | 1 | Current data toggle (0 DATA0, 1 DATA1) |

## Verification
Three pairs of functions can land in the same cycle, and the bench drives each pair together as a single vector.

The first pair is a software write and a token start. That vector writes short-packet at the same edge as `tok_start` with an empty FIFO, and it passes only if the answer stays NAK while the readback already shows the new bit.

The second pair is a toggle write and a SETUP completion. That vector writes a toggle clear on the same edge as `setup_done`, and it passes only if the toggle reads 1.

The third pair is a flag clear and a locked write. That vector writes force-NAK to 0 on the same edge as `setup_clr`, and it passes only if force-NAK still reads 1.

// File: rtl/ep_in_pkg.sv
package ep_in_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam int BIT_NAK   = 7;
  localparam int BIT_STALL = 6;
  localparam int BIT_SHORT = 5;
  localparam int BIT_TOG   = 2;
  localparam int BIT_TCLR  = 1;
  localparam int BIT_TSET  = 0;
endpackage

// File: rtl/ep_in_ctl_bits.sv
module ep_in_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_nak,
  input  logic wr_stall,
  input  logic wr_short,
  input  logic setup_done,
  input  logic setup_clr,
  input  logic short_done,
  output logic force_nak,
  output logic force_stall,
  output logic short_en,
  output logic setup_flag
);
  // SETUP wins over clear; the lock looks at the flag before this edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_flag  <= 1'b0;
      force_nak   <= 1'b0;
      force_stall <= 1'b0;
      short_en    <= 1'b0;
    end else begin
      if (setup_done)     setup_flag <= 1'b1;
      else if (setup_clr) setup_flag <= 1'b0;

      if (setup_done) begin
        force_nak   <= 1'b1;
        force_stall <= 1'b0;
      end else if (wr && !setup_flag) begin
        force_nak   <= wr_nak;
        force_stall <= wr_stall;
      end

      // a fresh write of the request outranks the self-clear
      if (wr)              short_en <= wr_short;
      else if (short_done) short_en <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_in_toggle.sv
module ep_in_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_done,
  input  logic wr,
  input  logic wr_set,
  input  logic wr_clr,
  input  logic ack_data,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (!rst_n)                tog <= 1'b0;
    else if (setup_done)       tog <= 1'b1;
    else if (wr && wr_set)     tog <= 1'b1;
    else if (wr && wr_clr)     tog <= 1'b0;
    else if (ack_data)         tog <= ~tog;
  end
endmodule

// File: rtl/ep_in_resp_latch.sv
module ep_in_resp_latch
  import ep_in_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int MPS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_start,
  input  logic             pkt_sent,
  input  logic             host_ack,
  input  logic             setup_done,
  input  logic             force_nak,
  input  logic             force_stall,
  input  logic             short_en,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             active,
  output hs_e              resp,
  output logic             short_done,
  output logic             ack_data
);
  localparam logic [LVL_W-1:0] MPS_L = LVL_W'(MPS);

  hs_e decide;
  logic data_xact, done;

  always_comb begin
    if (force_stall)                              decide = HS_STALL;
    else if (force_nak)                           decide = HS_NAK;
    else if (short_en || (fifo_level >= MPS_L))   decide = HS_DATA;
    else                                          decide = HS_NAK;
  end

  assign data_xact  = active && (resp == HS_DATA);
  assign short_done = data_xact && pkt_sent;
  assign ack_data   = data_xact && host_ack;
  assign done       = active && (host_ack || (pkt_sent && resp != HS_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n || setup_done) begin
      active <= 1'b0;
      resp   <= HS_IDLE;
    end else if (tok_start) begin
      active <= 1'b1;
      resp   <= decide;
    end else if (done) begin
      active <= 1'b0;
      resp   <= HS_IDLE;
    end
  end
endmodule

// File: rtl/ep_in_hs_ctrl.sv
module ep_in_hs_ctrl
  import ep_in_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int MPS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             setup_done,
  input  logic             setup_clr,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             tok_start,
  input  logic             pkt_sent,
  input  logic             host_ack,
  output logic             hs_valid,
  output logic [1:0]       hs_resp,
  output logic             data_pid
);
  logic force_nak, force_stall, short_en, setup_flag;
  logic short_done, ack_data, tog;
  hs_e  resp;

  ep_in_ctl_bits u_bits (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr),
    .wr_nak(reg_wdata[BIT_NAK]), .wr_stall(reg_wdata[BIT_STALL]),
    .wr_short(reg_wdata[BIT_SHORT]),
    .setup_done(setup_done), .setup_clr(setup_clr), .short_done(short_done),
    .force_nak(force_nak), .force_stall(force_stall),
    .short_en(short_en), .setup_flag(setup_flag)
  );

  ep_in_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .setup_done(setup_done), .wr(reg_wr),
    .wr_set(reg_wdata[BIT_TSET]), .wr_clr(reg_wdata[BIT_TCLR]),
    .ack_data(ack_data), .tog(tog)
  );

  ep_in_resp_latch #(.LVL_W(LVL_W), .MPS(MPS)) u_resp (
    .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .pkt_sent(pkt_sent),
    .host_ack(host_ack), .setup_done(setup_done),
    .force_nak(force_nak), .force_stall(force_stall), .short_en(short_en),
    .fifo_level(fifo_level), .active(hs_valid), .resp(resp),
    .short_done(short_done), .ack_data(ack_data)
  );

  always_comb begin
    reg_rdata            = 8'h00;
    reg_rdata[BIT_NAK]   = force_nak;
    reg_rdata[BIT_STALL] = force_stall;
    reg_rdata[BIT_SHORT] = short_en;
    reg_rdata[BIT_TOG]   = tog;
  end

  assign hs_resp  = resp;
  assign data_pid = tog;
endmodule

// File: rtl/ep_in_hs_chk.sv
module ep_in_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       setup_done,
  input logic       setup_flag,
  input logic       tok_start,
  input logic       pkt_sent,
  input logic       host_ack,
  input logic       hs_valid,
  input logic [1:0] hs_resp,
  input logic       data_pid
);
  // R5: pending flag keeps NAK on and STALL off
  a_r5_setup_lock: assert property (@(posedge clk) disable iff (!rst_n)
    setup_flag |-> (reg_rdata[7] && !reg_rdata[6]));

  // R2: STALL seen at token start wins
  a_r2_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_start && !setup_done && reg_rdata[6]) |=> (hs_resp == 2'd3));

  // R10: answer stays fixed inside a transaction
  a_r10_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !tok_start && !setup_done && !pkt_sent && !host_ack)
      |=> $stable(hs_resp));

  // R9: toggle moves only on ACK, write or SETUP
  a_r9_tog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ack && !reg_wr && !setup_done) |=> $stable(data_pid));

  // R7: short request drops after a sent DATA packet
  a_r7_short_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && hs_valid && hs_resp == 2'd1 && !reg_wr) |=> !reg_rdata[5]);

  // R11: reserved and strobe positions read zero
  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4:3] == 2'b00) && (reg_rdata[1:0] == 2'b00));

  // R1: idle answer when no transaction is open
  a_r1_idle_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_valid |-> (hs_resp == 2'd0));
endmodule

bind ep_in_hs_ctrl ep_in_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .setup_done(setup_done), .setup_flag(setup_flag), .tok_start(tok_start),
  .pkt_sent(pkt_sent), .host_ack(host_ack), .hs_valid(hs_valid),
  .hs_resp(hs_resp), .data_pid(data_pid)
);

// File: tb/tb_ep_in_hs_ctrl.sv
module tb_ep_in_hs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 8;

  typedef struct packed {
    logic       wr;  logic [7:0] wd;
    logic       su;  logic clr; logic tok; logic sent; logic ack;
    logic [7:0] lvl;
    logic [7:0] erd; logic ev; logic [1:0] ersp; logic etog;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b0,2'd0,1'b0,4'd1},  // R1 idle
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h0A, 8'h00,1'b1,2'd2,1'b0,4'd4},  // R4 too little data
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h00,1'b0,2'd0,1'b0,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h40, 8'h00,1'b1,2'd1,1'b0,4'd4},  // R4 full packet
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h00,1'b1,2'd1,1'b0,4'd9},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd9},  // R9 ack flips
    '{1'b1,8'hC0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'hC4,1'b0,2'd0,1'b1,4'd2},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h40, 8'hC4,1'b1,2'd3,1'b1,4'd2},  // R2 stall over nak
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'hC4,1'b0,2'd0,1'b1,4'd2},
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd3},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h40, 8'h84,1'b1,2'd2,1'b1,4'd3},  // R3 nak
    '{1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,8'h40, 8'h04,1'b1,2'd2,1'b1,4'd10}, // R10 mid write
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd10},
    '{1'b1,8'h20,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h24,1'b1,2'd2,1'b1,4'd10}, // R10 same edge
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h24,1'b0,2'd0,1'b1,4'd10},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05, 8'h24,1'b1,2'd1,1'b1,4'd7},  // R7 short data
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h04,1'b1,2'd1,1'b1,4'd7},  // R7 self clear
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b0,2'd0,1'b0,4'd9},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd5},  // R5 setup
    '{1'b1,8'h40,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd5},  // R5 locked
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h40, 8'h84,1'b1,2'd2,1'b1,4'd5},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd5},
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd6},
    '{1'b1,8'h40,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h44,1'b0,2'd0,1'b1,4'd6},  // R6 unlocked
    '{1'b1,8'h03,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd8},  // R8 set wins
    '{1'b1,8'h02,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b0,2'd0,1'b0,4'd8},
    '{1'b1,8'h19,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd11}, // R11 reserved
    '{1'b1,8'h02,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd8},  // R8 setup wins
    '{1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h84,1'b0,2'd0,1'b1,4'd5},  // R5 clr same edge
    '{1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd6},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h04,1'b1,2'd2,1'b1,4'd9},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd9},  // R9 nak ack
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h3F, 8'h04,1'b1,2'd2,1'b1,4'd4},  // R4 one short
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h04,1'b0,2'd0,1'b1,4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, setup_done = 1'b0, setup_clr = 1'b0;
  logic tok_start = 1'b0, pkt_sent = 1'b0, host_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [LVL_W-1:0] fifo_level = '0;
  logic hs_valid, data_pid;
  logic [1:0] hs_resp;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_in_hs_ctrl #(.LVL_W(LVL_W), .MPS(64)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .setup_done(setup_done), .setup_clr(setup_clr),
    .fifo_level(fifo_level), .tok_start(tok_start), .pkt_sent(pkt_sent),
    .host_ack(host_ack), .hs_valid(hs_valid), .hs_resp(hs_resp),
    .data_pid(data_pid)
  );

  task automatic check(input string req, input logic [7:0] erd, input logic ev,
                       input logic [1:0] ersp, input logic etog);
    n_chk++;
    if (reg_rdata !== erd || hs_valid !== ev || hs_resp !== ersp || data_pid !== etog) begin
      n_bad++;
      $display("FAIL %s: rd=%h v=%b r=%0d pid=%b expected rd=%h v=%b r=%0d pid=%b",
               req, reg_rdata, hs_valid, hs_resp, data_pid, erd, ev, ersp, etog);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 0; reg_wdata = 0; setup_done = 0; setup_clr = 0;
    tok_start = 0; pkt_sent = 0; host_ack = 0; fifo_level = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1", 8'h00, 1'b0, 2'd0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VECS[i].wr; reg_wdata = VECS[i].wd; setup_done = VECS[i].su;
      setup_clr = VECS[i].clr; tok_start = VECS[i].tok; pkt_sent = VECS[i].sent;
      host_ack = VECS[i].ack; fifo_level = VECS[i].lvl;
      @(posedge clk); #1;
      check($sformatf("R%0d vec%0d", VECS[i].rq, i),
            VECS[i].erd, VECS[i].ev, VECS[i].ersp, VECS[i].etog);
    end
    // R5 with R10: setup in the same cycle as a token start cancels the answer
    @(negedge clk); idle_inputs(); setup_done = 1; tok_start = 1; fifo_level = 8'h40;
    @(posedge clk); #1; check("R5 setup vs token", 8'h84, 1'b0, 2'd0, 1'b1);
    // R7: a write of the request in the self-clear cycle keeps it
    @(negedge clk); idle_inputs(); setup_clr = 1;
    @(negedge clk); idle_inputs(); reg_wr = 1; reg_wdata = 8'h20;
    @(negedge clk); idle_inputs(); tok_start = 1;
    @(negedge clk); idle_inputs(); pkt_sent = 1; reg_wr = 1; reg_wdata = 8'h20;
    @(posedge clk); #1; check("R7 rewrite wins", 8'h24, 1'b1, 2'd1, 1'b1);
    // R1: reset mid-run restores the idle state
    @(negedge clk); idle_inputs(); reg_wr = 1; reg_wdata = 8'hE1;
    @(negedge clk); idle_inputs(); rst_n = 0;
    @(posedge clk); #1; check("R1 reset", 8'h00, 1'b0, 2'd0, 1'b0);
    @(negedge clk); rst_n = 1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule